// File: doc/BRIEF.md
# Operand Wakeup and Execution-Unit Select

This block keeps readiness state for every slot of an out-of-order commit queue and picks which waiting instructions go to the execution units each cycle. Every slot holds an instruction's unit type, its operation code and up to two source references. A reference names either an architectural register or another queue slot, the producer. A slot becomes eligible once each used source is architectural, or points at a producer that has completed or is completing in this same cycle (bypass).

Eligible slots contend for units of their type. There are two integer ports and one branch port. Age, counted from the queue head, decides which slot wins. When a producer retires, every consumer still pointing at it is rewritten to point at the architectural register the renamer recorded next to the slot reference. Truncation and flush arrive as a kill vector. A kill takes effect in the cycle it is asserted.

The issue ports are one-cycle strobes with no ready signal. An execution unit that cannot take work raises its busy pin, and the block then grants it nothing. Allocation is a plain write into the slot named by the caller, and it cannot be refused.

Top module: `wakeup_select`

## Requirements
- R1: After reset no slot is valid and every bit of `iss_valid` is 0.
- R2: A slot allocated at clock edge t whose used sources are all architectural (or whose sources are unused) issues combinationally in the cycle after edge t, provided a port of its type is free.
- R3: A slot with a queue-slot source does not issue until that producer has signalled completion on `done_vec`. Completion is remembered, so a consumer allocated later, against a producer that has already completed, issues without waiting.
- R4: A producer whose `done_vec` bit is high in the current cycle satisfies its consumers in that same cycle (bypass).
- R5: When `retire_vec` marks a producer, each consumer source that refers to it becomes architectural from the next cycle. The architectural number it then uses is the one that was allocated with that source.
- R6: Among contending slots of one unit type, the slot nearest the head wins. Age runs upward from `head_idx` and wraps modulo the slot count.
- R7: The integer ports are filled in port order with the oldest contenders first. A port whose `unit_busy` bit is 1 is granted nothing, and its candidate passes to the next free integer port. No slot is granted to two ports.
- R8: Unit type 0 is integer and 1 is branch. Port indexes 0 and 1 serve integer slots only, and port index 2 serves branch slots only.
- R9: A slot that has been granted does not contend again until it is reallocated.
- R10: A slot whose `kill_vec` bit is 1 is not granted in that cycle and is invalid afterwards.
- R11: Each issuing port presents the slot index, the operation code and two source references. A reference is 7 bits: bit 6 is 1 for a queue-slot reference. Bits 5:0 hold either the slot number, zero-extended, or the architectural register number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_idx | input | QW | Oldest queue slot |
| alloc_valid | input | 1 | Write a new instruction into a slot |
| alloc_idx | input | QW | Slot being written |
| alloc_utype | input | 1 | Unit type: 0 integer, 1 branch |
| alloc_op | input | OPW | Operation code |
| alloc_used | input | 2 | Per-source: source is used |
| alloc_inq | input | 2 | Per-source: source refers to a queue slot |
| alloc_qidx | input | 2*QW | Per-source producer slot |
| alloc_areg | input | 2*AW | Per-source architectural register |
| done_vec | input | NENT | Slots completing this cycle |
| retire_vec | input | NENT | Slots retiring this cycle |
| kill_vec | input | NENT | Slots discarded this cycle |
| unit_busy | input | NINT+1 | Unit cannot accept work this cycle |
| iss_valid | output | NINT+1 | Port issues this cycle |
| iss_idx | output | (NINT+1)*QW | Issued slot per port |
| iss_op | output | (NINT+1)*OPW | Operation code per port |
| iss_src | output | (NINT+1)*2*(AW+1) | Two source references per port |

## Verification
The embedded properties assume a well-behaved allocator. It never writes a slot that is still valid, never asserts `done_vec` for a slot in the cycle it is allocated, and only retires producers that have already been issued. The stimulus respects this: it discards every slot with a full kill before each new scenario, and it holds all units busy while slots are being loaded, so that grants happen only in the cycles being checked. Retire and completion strobes are applied only to slots that have already issued.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic {UT_INT = 1'b0, UT_BR = 1'b1} utype_e;
endpackage

// File: rtl/age_pick.sv
module age_pick #(
  parameter int N  = 8,
  parameter int QW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [QW-1:0] head,
  output logic          found,
  output logic [QW-1:0] idx
);
  // Scan from youngest to oldest so the oldest hit is written last.
  always_comb begin
    found = 1'b0;
    idx   = head;
    for (int j = N - 1; j >= 0; j--) begin
      int k;
      k = (int'(head) + j) % N;
      if (req[k]) begin
        found = 1'b1;
        idx   = QW'(k);
      end
    end
  end
endmodule

// File: rtl/sched_slot.sv
module sched_slot
  import sched_pkg::*;
#(
  parameter int NENT = 8,
  parameter int IDX  = 0,
  parameter int QW   = $clog2(NENT),
  parameter int AW   = 6,
  parameter int OPW  = 5,
  localparam int RW  = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_en,
  input  utype_e          a_utype,
  input  logic [OPW-1:0]  a_op,
  input  logic [1:0]      a_used,
  input  logic [1:0]      a_inq,
  input  logic [2*QW-1:0] a_qidx,
  input  logic [2*AW-1:0] a_areg,
  input  logic [NENT-1:0] done_vec,
  input  logic [NENT-1:0] retire_vec,
  input  logic [NENT-1:0] comp_vec,
  input  logic            kill,
  input  logic            grant,
  output logic            req,
  output logic            comp,
  output logic            is_br,
  output logic [OPW-1:0]  op,
  output logic [2*RW-1:0] src_ref
);
  logic           vld_q, iss_q, comp_q;
  utype_e         ut_q;
  logic [OPW-1:0] op_q;
  logic [1:0]     used_q, inq_q, rdy;
  logic [QW-1:0]  qidx_q [2];
  logic [AW-1:0]  areg_q [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      iss_q  <= 1'b0;
      comp_q <= 1'b0;
      ut_q   <= UT_INT;
      op_q   <= '0;
      used_q <= '0;
      inq_q  <= '0;
      for (int s = 0; s < 2; s++) begin
        qidx_q[s] <= '0;
        areg_q[s] <= '0;
      end
    end else if (alloc_en) begin
      vld_q  <= 1'b1;
      iss_q  <= 1'b0;
      comp_q <= 1'b0;
      ut_q   <= a_utype;
      op_q   <= a_op;
      used_q <= a_used;
      for (int s = 0; s < 2; s++) begin
        // A producer retiring while its consumer is written is already architectural.
        inq_q[s]  <= a_inq[s] & ~retire_vec[a_qidx[s*QW +: QW]];
        qidx_q[s] <= a_qidx[s*QW +: QW];
        areg_q[s] <= a_areg[s*AW +: AW];
      end
    end else begin
      if (kill || retire_vec[IDX]) vld_q <= 1'b0;
      if (grant)                   iss_q <= 1'b1;
      if (done_vec[IDX])           comp_q <= 1'b1;
      for (int s = 0; s < 2; s++)
        if (inq_q[s] && retire_vec[qidx_q[s]]) inq_q[s] <= 1'b0;
    end
  end

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      rdy[s] = !used_q[s] || !inq_q[s] || comp_vec[qidx_q[s]] || done_vec[qidx_q[s]];
      src_ref[s*RW +: RW] = inq_q[s] ? {1'b1, AW'(qidx_q[s])} : {1'b0, areg_q[s]};
    end
  end

  assign req   = vld_q && !iss_q && !kill && (&rdy);
  assign comp  = comp_q;
  assign is_br = (ut_q == UT_BR);
  assign op    = op_q;

  for (genvar s = 0; s < 2; s++) begin : g_chk
    // R5
    retarget_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && !alloc_en && inq_q[s] && retire_vec[qidx_q[s]]) |=> !src_ref[s*RW + RW - 1]);
  end
endmodule

// File: rtl/wakeup_select.sv
module wakeup_select
  import sched_pkg::*;
#(
  parameter int NENT  = 8,
  parameter int AW    = 6,
  parameter int OPW   = 5,
  parameter int NINT  = 2,
  localparam int QW    = $clog2(NENT),
  localparam int RW    = AW + 1,
  localparam int NPORT = NINT + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [QW-1:0]         head_idx,
  input  logic                  alloc_valid,
  input  logic [QW-1:0]         alloc_idx,
  input  logic                  alloc_utype,
  input  logic [OPW-1:0]        alloc_op,
  input  logic [1:0]            alloc_used,
  input  logic [1:0]            alloc_inq,
  input  logic [2*QW-1:0]       alloc_qidx,
  input  logic [2*AW-1:0]       alloc_areg,
  input  logic [NENT-1:0]       done_vec,
  input  logic [NENT-1:0]       retire_vec,
  input  logic [NENT-1:0]       kill_vec,
  input  logic [NPORT-1:0]      unit_busy,
  output logic [NPORT-1:0]      iss_valid,
  output logic [NPORT*QW-1:0]   iss_idx,
  output logic [NPORT*OPW-1:0]  iss_op,
  output logic [NPORT*2*RW-1:0] iss_src
);
  logic [NENT-1:0] req_vec, comp_vec, br_vec, gnt_any;
  logic [OPW-1:0]  op_arr  [NENT];
  logic [2*RW-1:0] src_arr [NENT];
  logic [NENT-1:0] rem     [NINT+1];
  logic [NENT-1:0] gvec    [NPORT];
  logic [QW-1:0]   pidx    [NPORT];
  logic [NPORT-1:0] pfound;

  for (genvar i = 0; i < NENT; i++) begin : g_slot
    sched_slot #(.NENT(NENT), .IDX(i), .QW(QW), .AW(AW), .OPW(OPW)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(alloc_valid && (alloc_idx == QW'(i))),
      .a_utype(utype_e'(alloc_utype)), .a_op(alloc_op),
      .a_used(alloc_used), .a_inq(alloc_inq),
      .a_qidx(alloc_qidx), .a_areg(alloc_areg),
      .done_vec(done_vec), .retire_vec(retire_vec), .comp_vec(comp_vec),
      .kill(kill_vec[i]), .grant(gnt_any[i]),
      .req(req_vec[i]), .comp(comp_vec[i]), .is_br(br_vec[i]),
      .op(op_arr[i]), .src_ref(src_arr[i]));
  end

  assign rem[0] = req_vec & ~br_vec;

  // Integer ports take the oldest remaining contender, in port order.
  for (genvar p = 0; p < NINT; p++) begin : g_int
    age_pick #(.N(NENT), .QW(QW)) u_pick (
      .req(rem[p] & {NENT{~unit_busy[p]}}), .head(head_idx),
      .found(pfound[p]), .idx(pidx[p]));
    assign gvec[p]  = pfound[p] ? (NENT'(1) << pidx[p]) : '0;
    assign rem[p+1] = rem[p] & ~gvec[p];
  end

  age_pick #(.N(NENT), .QW(QW)) u_pick_br (
    .req(req_vec & br_vec & {NENT{~unit_busy[NINT]}}), .head(head_idx),
    .found(pfound[NINT]), .idx(pidx[NINT]));
  assign gvec[NINT] = pfound[NINT] ? (NENT'(1) << pidx[NINT]) : '0;

  always_comb begin
    gnt_any = '0;
    for (int p = 0; p < NPORT; p++) begin
      gnt_any |= gvec[p];
      iss_idx[p*QW +: QW]       = pidx[p];
      iss_op[p*OPW +: OPW]      = op_arr[pidx[p]];
      iss_src[p*2*RW +: 2*RW]   = src_arr[pidx[p]];
    end
  end

  assign iss_valid = pfound;

  // R7
  grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gnt_any) == $countones(iss_valid));
  // R7
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_busy & iss_valid) == '0);
  // R10
  kill_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_vec & gnt_any) == '0);
  // R8
  br_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[NINT] |-> br_vec[pidx[NINT]]);
  for (genvar p = 0; p < NINT; p++) begin : g_tchk
    // R8
    int_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[p] |-> !br_vec[pidx[p]]);
  end
  for (genvar i = 0; i < NENT; i++) begin : g_rchk
    // R9
    no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_any[i] && !(alloc_valid && alloc_idx == QW'(i))) |=> !gnt_any[i]);
  end
endmodule

// File: tb/wakeup_select_bench.sv
module wakeup_select_bench;
  localparam int NENT = 8, AW = 6, OPW = 5, NINT = 2;
  localparam int QW = 3, RW = 7, NP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [QW-1:0] head_idx = '0;
  logic alloc_valid = 1'b0, alloc_utype = 1'b0;
  logic [QW-1:0] alloc_idx = '0;
  logic [OPW-1:0] alloc_op = '0;
  logic [1:0] alloc_used = '0, alloc_inq = '0;
  logic [2*QW-1:0] alloc_qidx = '0;
  logic [2*AW-1:0] alloc_areg = '0;
  logic [NENT-1:0] done_vec = '0, retire_vec = '0, kill_vec = '0;
  logic [NP-1:0] unit_busy = '1;
  logic [NP-1:0] iss_valid;
  logic [NP*QW-1:0] iss_idx;
  logic [NP*OPW-1:0] iss_op;
  logic [NP*2*RW-1:0] iss_src;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wakeup_select #(.NENT(NENT), .AW(AW), .OPW(OPW), .NINT(NINT)) u_wakeup_select (
    .clk, .rst_n, .head_idx, .alloc_valid, .alloc_idx, .alloc_utype, .alloc_op,
    .alloc_used, .alloc_inq, .alloc_qidx, .alloc_areg, .done_vec, .retire_vec,
    .kill_vec, .unit_busy, .iss_valid, .iss_idx, .iss_op, .iss_src);

  // {int mask, branch mask, head, busy, expected valid, exp idx p0, p1, p2}
  localparam logic [33:0] VEC [8] = '{
    {8'h0F, 8'h00, 3'd0, 3'b000, 3'b011, 3'd0, 3'd1, 3'd0},
    {8'h0F, 8'h00, 3'd2, 3'b000, 3'b011, 3'd2, 3'd3, 3'd0},
    {8'h81, 8'h00, 3'd4, 3'b000, 3'b011, 3'd7, 3'd0, 3'd0},
    {8'h0F, 8'h30, 3'd5, 3'b000, 3'b111, 3'd0, 3'd1, 3'd5},
    {8'h06, 8'h00, 3'd0, 3'b001, 3'b010, 3'd0, 3'd1, 3'd0},
    {8'h00, 8'hC0, 3'd7, 3'b000, 3'b100, 3'd0, 3'd0, 3'd7},
    {8'h20, 8'h00, 3'd0, 3'b000, 3'b001, 3'd5, 3'd0, 3'd0},
    {8'h0F, 8'h10, 3'd0, 3'b011, 3'b100, 3'd0, 3'd0, 3'd4}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic put(input int idx, input logic ut, input logic [OPW-1:0] op,
                     input logic [1:0] used, input logic [1:0] inq,
                     input logic [2*QW-1:0] qi, input logic [2*AW-1:0] ar);
    alloc_valid = 1'b1; alloc_idx = QW'(idx); alloc_utype = ut; alloc_op = op;
    alloc_used = used; alloc_inq = inq; alloc_qidx = qi; alloc_areg = ar;
    tick();
    alloc_valid = 1'b0;
  endtask

  task automatic flush_all();
    unit_busy = '1; kill_vec = '1; tick(); kill_vec = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    unit_busy = '0;
    @(negedge clk);
    check("R1 idle after reset", 32'(iss_valid), 0);

    // Table walk: R2 R6 R7 R8
    foreach (VEC[r]) begin
      logic [33:0] v;
      v = VEC[r];
      flush_all();
      for (int i = 0; i < NENT; i++)
        if (v[26+i] || v[18+i]) put(i, v[18+i], OPW'(i), 2'b00, 2'b00, '0, '0);
      head_idx = v[17:15]; unit_busy = v[14:12];
      @(negedge clk);
      check($sformatf("R6 R7 R8 row %0d valid", r), 32'(iss_valid), 32'(v[11:9]));
      for (int p = 0; p < NP; p++)
        if (v[9+p])
          check($sformatf("R6 R7 R8 row %0d port %0d idx", r, p),
                32'(iss_idx[p*QW +: QW]), 32'(v[8-3*p -: 3]));
      tick();
    end
    head_idx = '0;

    // R2 R3 R4 R9 R11: producer on branch unit, consumer waits for it
    flush_all();
    put(0, 1'b1, 5'h12, 2'b00, 2'b00, '0, '0);
    put(1, 1'b0, 5'h03, 2'b01, 2'b01, 6'd0, {6'd0, 6'd7});
    unit_busy = '0;
    @(negedge clk);
    check("R2 branch producer issues", 32'(iss_valid), 32'b100);
    check("R11 branch op", 32'(iss_op[2*OPW +: OPW]), 32'h12);
    check("R11 branch idx", 32'(iss_idx[2*QW +: QW]), 0);
    tick();
    @(negedge clk);
    check("R3 consumer waits, R9 no reissue", 32'(iss_valid), 0);
    tick();
    done_vec = 8'h01;
    #0.5;
    check("R4 bypass issue valid", 32'(iss_valid), 32'b001);
    check("R4 bypass issue idx", 32'(iss_idx[0 +: QW]), 1);
    check("R11 queue ref", 32'(iss_src[0 +: RW]), 32'h40);
    tick();
    done_vec = '0;
    @(negedge clk);
    check("R9 issued slot quiet", 32'(iss_valid), 0);

    // R3: completion remembered
    unit_busy = '1;
    put(2, 1'b0, 5'h04, 2'b01, 2'b01, 6'd0, 12'd0);
    unit_busy = '0;
    @(negedge clk);
    check("R3 remembered completion", 32'(iss_valid), 32'b001);
    check("R3 remembered idx", 32'(iss_idx[0 +: QW]), 2);
    tick();

    // R5: producer slot 1 retires, consumer retargets to arch 21
    unit_busy = '1;
    put(3, 1'b0, 5'h05, 2'b11, 2'b01, {3'd0, 3'd1}, {6'd9, 6'd21});
    retire_vec = 8'h02;
    tick();
    retire_vec = '0; unit_busy = '0;
    @(negedge clk);
    check("R5 retargeted slot issues", 32'(iss_valid), 32'b001);
    check("R5 retarget idx", 32'(iss_idx[0 +: QW]), 3);
    check("R5 src0 arch ref", 32'(iss_src[0 +: RW]), 21);
    check("R11 src1 arch ref", 32'(iss_src[RW +: RW]), 9);
    tick();

    // R10: kill in the cycle it would issue
    unit_busy = '1;
    put(4, 1'b0, 5'h06, 2'b00, 2'b00, '0, '0);
    kill_vec = 8'h10; unit_busy = '0;
    @(negedge clk);
    check("R10 killed slot not granted", 32'(iss_valid), 0);
    tick();
    kill_vec = '0;
    @(negedge clk);
    check("R10 killed slot stays gone", 32'(iss_valid), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule